// File: doc/BRIEF.md
# Count-Down Timer with Watchdog Stage

This block is a register-mapped timer whose 29-bit counter steps down by one on every cycle in which an external 1 MHz tick enable is high. Software programs a reload count together with an enable bit and a mode bit. In periodic mode the counter reloads at each expiry and keeps running. In one-shot mode it stops at zero and drops its own enable. Every expiry latches a pending flag, which drives a level interrupt.

A watchdog stage sits behind the expiry logic. Each expiry is counted as a miss. Any read of the control register counts as service and clears the miss count. When two expiries in a row pass with no service, a reset-request output rises. Clearing the interrupt takes two steps. A write-one-to-clear to the status register arms the clear, and the interrupt falls only on the next control register read. A control write with the enable bit low stops both the counter and the watchdog.

The tick source and any sharing among several timers lie outside the block.

Top module: `countdown_watchdog_timer`

## Requirements
- R1: After reset, irq and dogReset are low and both registers read as zero.
- R2: The control register is at address 0. Bit 31 is enable, bit 30 selects periodic mode (1) or one-shot mode (0), bits 28:0 hold the reload count, and every other bit reads 0. A write to it stores these fields and loads the live count from bits 28:0.
- R3: While enabled, the live count drops by one on each cycle with tickEn high that does not reach zero. It holds on cycles with tickEn low.
- R4: After a reload count N is written, the expiry lands on the (N+1)th tick. The expiry sets the pending flag, and irq follows it one cycle later.
- R5: At expiry, periodic mode reloads the live count from the reload field and stays enabled. One-shot mode clears the enable bit and leaves the live count at 0.
- R6: The status register is at address 1. Bit 30 reads the pending flag, bits 28:0 read the live count, and the other bits read 0. A status write with bit 30 low has no effect.
- R7: A status write with bit 30 high does not drop irq by itself. The next control-register read then clears the pending flag. A control read with no prior clear write leaves irq set. An expiry in the same cycle as the clearing read keeps the pending flag set.
- R8: dogReset rises after the second expiry with no control-register read between the two. Any control-register read clears the miss count and drops dogReset. A read in the same cycle as an expiry leaves that expiry counted as one miss.
- R9: A control write with bit 31 low stops the count and clears the miss count, so dogReset is low in the next cycle.
- R10: A control write in the same cycle as a tick takes precedence: the written count is loaded and that tick is not applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | 1 MHz count enable, one clock wide per tick |
| addr | input | ADDR_W | Register word address (0 control, 1 status) |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Register write data |
| rdEn | input | 1 | Register read strobe; a control read services the watchdog |
| rdData | output | 32 | Read data for addr, combinational |
| irq | output | 1 | Level interrupt, the pending flag |
| dogReset | output | 1 | Watchdog reset request |

## Verification
The bench builds the block with its default parameters: a 29-bit counter, a one-bit address and a miss limit of two. Software sets the reload count, so small reload values of 0 to 7 bring expiry, periodic reload and the two-miss watchdog within a few cycles. The full-width datapath is still exercised. Random mixes of ticks, control and status writes and reads fall on the same-cycle collisions of expiry with a clearing read and of a write with a tick. Directed sequences pin the N+1 period, the one-shot stop and the two-step interrupt clear.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int REG_W   = 32;
  localparam int EN_BIT  = 31;
  localparam int PER_BIT = 30;
  localparam int CLR_BIT = 30;
  localparam int CTRL_IDX = 0;
  localparam int STAT_IDX = 1;

  typedef struct packed {
    logic ctrlWr;
    logic tickGo;
  } cdtStrobe_t;
endpackage

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
#(
  parameter int ADDR_W = 1,
  parameter int MISS_LIMIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              wrEnableBit,
  input  logic              wrClrBit,
  input  logic              expirePulse,
  output cdtStrobe_t        strobe,
  output logic              pending,
  output logic              dogReset
);
  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [MISS_W-1:0] MISS_MAX = MISS_W'(MISS_LIMIT);

  logic ctrlSel, statSel, trigRead, clrReq, stopReq;
  logic clrArmed;
  logic [MISS_W-1:0] missCnt;

  assign ctrlSel  = (addr == ADDR_W'(CTRL_IDX));
  assign statSel  = (addr == ADDR_W'(STAT_IDX));
  assign trigRead = rdEn && ctrlSel;
  assign clrReq   = wrEn && statSel && wrClrBit;
  assign stopReq  = strobe.ctrlWr && !wrEnableBit;

  always_comb begin
    strobe.ctrlWr = wrEn && ctrlSel;
    strobe.tickGo = tickEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      clrArmed <= 1'b0;
      missCnt  <= '0;
    end else begin
      if (expirePulse) pending <= 1'b1;
      else if (trigRead && clrArmed) pending <= 1'b0;

      if (clrReq) clrArmed <= 1'b1;
      else if (trigRead) clrArmed <= 1'b0;

      if (stopReq) missCnt <= '0;
      else if (expirePulse) begin
        if (trigRead) missCnt <= MISS_W'(1);
        else if (missCnt != MISS_MAX) missCnt <= missCnt + 1'b1;
      end else if (trigRead) missCnt <= '0;
    end
  end

  assign dogReset = (missCnt == MISS_MAX);
endmodule

// File: rtl/cdt_datapath.sv
module cdt_datapath
  import cdt_pkg::*;
#(
  parameter int CNT_W = 29,
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  cdtStrobe_t        strobe,
  input  logic              wrEnableBit,
  input  logic              wrPeriodicBit,
  input  logic [CNT_W-1:0]  wrCount,
  input  logic [ADDR_W-1:0] addr,
  input  logic              pending,
  output logic              expirePulse,
  output logic              timerEn,
  output logic              timerPeriodic,
  output logic [CNT_W-1:0]  liveCount,
  output logic [CNT_W-1:0]  reloadVal,
  output logic [REG_W-1:0]  rdData
);
  logic atZero;
  logic [REG_W-1:0] ctrlWord, statWord;

  assign atZero      = (liveCount == '0);
  assign expirePulse = timerEn && strobe.tickGo && !strobe.ctrlWr && atZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerEn       <= 1'b0;
      timerPeriodic <= 1'b0;
      reloadVal     <= '0;
      liveCount     <= '0;
    end else if (strobe.ctrlWr) begin
      timerEn       <= wrEnableBit;
      timerPeriodic <= wrPeriodicBit;
      reloadVal     <= wrCount;
      liveCount     <= wrCount;
    end else if (timerEn && strobe.tickGo) begin
      if (!atZero) liveCount <= liveCount - 1'b1;
      else if (timerPeriodic) liveCount <= reloadVal;
      else timerEn <= 1'b0;
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[EN_BIT] = timerEn;
    ctrlWord[PER_BIT] = timerPeriodic;
    ctrlWord[CNT_W-1:0] = reloadVal;
    statWord = '0;
    statWord[CLR_BIT] = pending;
    statWord[CNT_W-1:0] = liveCount;
    if (addr == ADDR_W'(CTRL_IDX)) rdData = ctrlWord;
    else if (addr == ADDR_W'(STAT_IDX)) rdData = statWord;
    else rdData = '0;
  end
endmodule

// File: rtl/countdown_watchdog_timer.sv
module countdown_watchdog_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W = 29,
  parameter int ADDR_W = 1,
  parameter int MISS_LIMIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [REG_W-1:0]  wrData,
  input  logic              rdEn,
  output logic [REG_W-1:0]  rdData,
  output logic              irq,
  output logic              dogReset
);
  cdtStrobe_t strobe;
  logic expirePulse, pending, timerEn, timerPeriodic;
  logic [CNT_W-1:0] liveCount, reloadVal;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData;

  cdt_ctrl #(.ADDR_W(ADDR_W), .MISS_LIMIT(MISS_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr),
    .wrEn(wrEn), .rdEn(rdEn),
    .wrEnableBit(wrData[EN_BIT]), .wrClrBit(wrData[CLR_BIT]),
    .expirePulse(expirePulse), .strobe(strobe),
    .pending(pending), .dogReset(dogReset)
  );

  cdt_datapath #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrEnableBit(wrData[EN_BIT]), .wrPeriodicBit(wrData[PER_BIT]),
    .wrCount(wrData[CNT_W-1:0]), .addr(addr), .pending(pending),
    .expirePulse(expirePulse), .timerEn(timerEn),
    .timerPeriodic(timerPeriodic), .liveCount(liveCount),
    .reloadVal(reloadVal), .rdData(rdData)
  );

  assign irq = pending;
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
  parameter int CNT_W = 29,
  parameter int ADDR_W = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] addr,
  input logic              wrEn,
  input logic              wrEnBit,
  input logic              rdEn,
  input logic              irq,
  input logic              dogReset,
  input logic              expirePulse,
  input logic              timerEn,
  input logic              timerPeriodic,
  input logic [CNT_W-1:0]  liveCount,
  input logic [CNT_W-1:0]  reloadVal
);
  logic ctrlWrite, ctrlRead;
  assign ctrlWrite = wrEn && (addr == '0);
  assign ctrlRead  = rdEn && (addr == '0);

  assert_decrement_R3: assert property (@(posedge clk) disable iff (!rstN)
    timerEn && tickEn && !ctrlWrite && liveCount != '0 |=> liveCount == $past(liveCount) - 1'b1);
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn && !ctrlWrite |=> $stable(liveCount));
  assert_irq_set_R4: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse |=> irq);
  assert_oneshot_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse && !timerPeriodic |=> !timerEn && liveCount == '0);
  assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rstN)
    expirePulse && timerPeriodic |=> timerEn && liveCount == $past(reloadVal));
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(ctrlRead));
  assert_dog_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dogReset) |-> $past(expirePulse));
  assert_stop_R9: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWrite && !wrEnBit |=> !dogReset && !timerEn);
endmodule

bind countdown_watchdog_timer cdt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
  .wrEnBit(wrData[31]), .rdEn(rdEn), .irq(irq), .dogReset(dogReset),
  .expirePulse(expirePulse), .timerEn(timerEn), .timerPeriodic(timerPeriodic),
  .liveCount(liveCount), .reloadVal(reloadVal)
);

// File: tb/countdown_watchdog_timer_bench.sv
`timescale 1ns/1ps
module countdown_watchdog_timer_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [0:0] addr = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic irq, dogReset;
  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  countdown_watchdog_timer u_countdown_watchdog_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .addr(addr), .wrEn(wrEn),
    .wrData(wrData), .rdEn(rdEn), .rdData(rdData), .irq(irq), .dogReset(dogReset)
  );

  // reference state, updated from the requirements
  logic mEn, mPer, mPend, mArm;
  logic [28:0] mReload, mCount;
  int mMiss;

  function automatic logic [31:0] modelRead(logic a);
    if (a == 1'b0) return {mEn, mPer, 1'b0, mReload};
    return {1'b0, mPend, 1'b0, mCount};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tickEn = 0; wrEn = 0; rdEn = 0; addr = 0; wrData = '0;
    repeat (3) @(negedge clk);
    mEn = 0; mPer = 0; mPend = 0; mArm = 0; mReload = '0; mCount = '0; mMiss = 0;
    rstN = 1'b1;
  endtask

  task automatic runCycle(input logic t, input logic w, input logic r,
                          input logic a, input logic [31:0] d, input string tag);
    logic cw, sw, tr, ex;
    logic nEn, nPer, nPend, nArm;
    logic [28:0] nReload, nCount;
    int nMiss;
    tickEn = t; wrEn = w; rdEn = r; addr = a; wrData = d;
    #1;
    if (r) check(tag, rdData, modelRead(a));
    cw = w && (a == 1'b0);
    sw = w && (a == 1'b1);
    tr = r && (a == 1'b0);
    ex = mEn && t && !cw && (mCount == 0);
    nEn = mEn; nPer = mPer; nReload = mReload; nCount = mCount;
    if (cw) begin
      nEn = d[31]; nPer = d[30]; nReload = d[28:0]; nCount = d[28:0];
    end else if (mEn && t) begin
      if (mCount != 0) nCount = mCount - 1;
      else if (mPer) nCount = mReload;
      else nEn = 1'b0;
    end
    nPend = ex ? 1'b1 : ((tr && mArm) ? 1'b0 : mPend);
    nArm = (sw && d[30]) ? 1'b1 : (tr ? 1'b0 : mArm);
    if (cw && !d[31]) nMiss = 0;
    else if (ex) nMiss = tr ? 1 : ((mMiss < 2) ? mMiss + 1 : 2);
    else if (tr) nMiss = 0;
    else nMiss = mMiss;
    @(posedge clk);
    mEn = nEn; mPer = nPer; mReload = nReload; mCount = nCount;
    mPend = nPend; mArm = nArm; mMiss = nMiss;
    @(negedge clk);
    check("R4 irq", {31'b0, irq}, {31'b0, mPend});
    check("R8 dogReset", {31'b0, dogReset}, {31'b0, (mMiss == 2)});
    tickEn = 0; wrEn = 0; rdEn = 0; wrData = '0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) runCycle(1, 0, 0, 0, '0, "tick");
  endtask

  task automatic readReg(logic a, logic [31:0] exp, string tag);
    tickEn = 0; wrEn = 0; rdEn = 1; addr = a;
    #1;
    check(tag, rdData, exp);
    runCycle(0, 0, 1, a, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int firstIrq;
    void'($urandom(32'd4242));
    doReset();
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'd0);
    check("R1 dogReset", {31'b0, dogReset}, 32'd0);
    readReg(0, 32'h0000_0000, "R1 ctrl");
    readReg(1, 32'h0000_0000, "R1 status");

    // R2 field layout and readback
    runCycle(0, 1, 0, 0, 32'hC000_0005, "R2 write");
    readReg(0, 32'hC000_0005, "R2 ctrl readback");
    readReg(1, 32'h0000_0005, "R2 count loaded");

    // R10 write beats a same-cycle tick
    runCycle(1, 1, 0, 0, 32'h8000_0006, "R10 write");
    readReg(1, 32'h0000_0006, "R10 tick ignored");

    // R3 decrement and hold
    doReset();
    runCycle(0, 1, 0, 0, 32'h8000_0005, "R3 write");
    ticks(2);
    readReg(1, 32'h0000_0003, "R3 after two ticks");
    repeat (3) runCycle(0, 0, 0, 0, '0, "idle");
    readReg(1, 32'h0000_0003, "R3 hold without tick");

    // R4 period N+1, R5 one-shot stop
    doReset();
    runCycle(0, 1, 0, 0, 32'h8000_0004, "R4 write");
    firstIrq = 0;
    for (int i = 1; i <= 8; i++) begin
      runCycle(1, 0, 0, 0, '0, "R4 tick");
      if (irq && firstIrq == 0) firstIrq = i;
    end
    check("R4 expiry tick", firstIrq, 32'd5);
    readReg(0, 32'h0000_0004, "R5 one-shot enable cleared");
    readReg(1, 32'h4000_0000, "R5 one-shot count at zero");

    // R5 periodic reload, R6 status write ignored
    doReset();
    runCycle(0, 1, 0, 0, 32'hC000_0002, "R5 write");
    ticks(3);
    readReg(1, 32'h4000_0002, "R5 periodic reloaded");
    runCycle(0, 1, 0, 1, 32'h0000_00FF, "R6 write");
    readReg(1, 32'h4000_0002, "R6 status write ignored");
    check("R6 irq kept", {31'b0, irq}, 32'd1);

    // R8 two misses, R7 two-step clear
    doReset();
    runCycle(0, 1, 0, 0, 32'hC000_0001, "R8 write");
    ticks(2);
    check("R8 one miss no reset", {31'b0, dogReset}, 32'd0);
    ticks(2);
    check("R8 second miss reset", {31'b0, dogReset}, 32'd1);
    readReg(0, 32'hC000_0001, "R8 service read");
    check("R8 cleared by read", {31'b0, dogReset}, 32'd0);
    check("R7 bare read keeps irq", {31'b0, irq}, 32'd1);
    runCycle(0, 1, 0, 1, 32'h4000_0000, "R7 clear write");
    check("R7 write alone keeps irq", {31'b0, irq}, 32'd1);
    readReg(1, 32'h4000_0001, "R7 status read keeps irq");
    check("R7 still pending", {31'b0, irq}, 32'd1);
    readReg(0, 32'hC000_0001, "R7 trigger read");
    check("R7 irq cleared", {31'b0, irq}, 32'd0);

    // R9 stop clears watchdog and count
    ticks(4);
    check("R9 reset armed", {31'b0, dogReset}, 32'd1);
    runCycle(0, 1, 0, 0, 32'h0000_0009, "R9 stop write");
    check("R9 dogReset cleared", {31'b0, dogReset}, 32'd0);
    ticks(3);
    readReg(1, 32'h4000_0009, "R9 count frozen");

    // random mix
    doReset();
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic t, w, rd, a;
      logic [31:0] d;
      r = $urandom_range(0, 99);
      t = ($urandom_range(0, 1) == 1);
      w = 0; rd = 0; a = 0; d = '0;
      if (r < 3) begin
        w = 1; a = 0;
        d = {($urandom_range(0, 9) != 0), 1'($urandom_range(0, 1)), 27'b0, 3'($urandom_range(0, 7))};
      end else if (r < 13) begin
        w = 1; a = 1;
        d = {1'b0, 1'($urandom_range(0, 1)), 22'b0, 8'($urandom_range(0, 255))};
      end else if (r < 20) begin
        rd = 1; a = 0;
      end else if (r < 30) begin
        rd = 1; a = 1;
      end
      runCycle(t, w, rd, a, d, "R6 random readback");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule